// File: doc/BRIEF.md
# ADC Result Holding Bank

This block keeps the latest 10-bit conversion result for each analog channel, so that a CPU can read it over a byte-wide bus. The converter side presents a channel number, a 10-bit value and a valid strobe. On that strobe the addressed channel captures the value and raises its store flag.

The CPU reads each channel as two bytes. The low byte is at even address `2*ch` and the high byte is at `2*ch+1`. The high byte carries the upper eight result bits. The low byte carries the two lowest result bits together with the status flags.

A result that arrives before both bytes of the previous one have been read raises an overrun flag. Reading the low byte is destructive: it clears both flags. Read data is combinational from the current register contents, and side effects take place at the clock edge that ends the read cycle.

Top module: `adc_result_bank`

## Requirements
- R1: After reset, every mapped address reads 0x00.
- R2: The high byte at address `2*ch+1` returns result bits 9..2 of that channel, and reading it has no effect on either flag.
- R3: The low byte at address `2*ch` returns result bits 1..0 in its bits 7..6. Its bits 5..2 always read 0.
- R4: A converter write (`cv_valid`=1) to a channel latches `cv_data` and sets that channel's store flag, which reads at low-byte bit 0.
- R5: An enabled read of a channel's low byte clears its store flag and its overrun flag (low-byte bit 1) at the end of that cycle.
- R6: A write to a channel whose previous result has not yet had both its bytes read sets the overrun flag. The flag stays set until the next low-byte read.
- R7: A write to a channel whose previous result had both bytes read leaves the overrun flag at 0.
- R8: A read of a high byte, a read of an unmapped address, or an address presented with `rd_en`=0 leaves every flag unchanged.
- R9: When a write and a low-byte read hit the same channel in the same cycle, the read returns the old contents. Afterwards the store flag is set, and the overrun flag is set if the high byte of the old result was never read.
- R10: An address at or above `2*NUM_CH` reads 0x00, and `rd_data` is 0x00 while `rd_en` is 0.
- R11: A write to one channel leaves the result and flags of every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | CPU read strobe |
| rd_addr | input | ADDR_W | CPU byte address |
| rd_data | output | 8 | Read data, combinational |
| cv_valid | input | 1 | Converter result valid |
| cv_chan | input | CH_W | Converter channel number |
| cv_data | input | 10 | Converter result |

## Verification
The hardest case to reach from the ports is a converter write and a low-byte read that land on the same channel in the same cycle. In that cycle the old data must come out while the new flags are being formed. The bench drives both strobes in one cycle and samples the read data before the edge. It then reads both bytes afterwards and checks the new result, the store flag and the overrun flag. The overrun flag comes from an unread high byte. Partial-read histories are built up first, so that overrun is seen to depend on which bytes were read and not only on the store flag.

// File: rtl/adc_result_pkg.sv
package adc_result_pkg;
  localparam int RES_W  = 10;
  localparam int BYTE_W = 8;
  localparam int LO_W   = RES_W - BYTE_W;

  // upper byte image of a result
  function automatic logic [BYTE_W-1:0] hi_image(input logic [RES_W-1:0] res);
    return res[RES_W-1:LO_W];
  endfunction

  // lower byte image: low result bits on top, flags at bit 1 and bit 0
  function automatic logic [BYTE_W-1:0] lo_image(input logic [RES_W-1:0] res,
                                                 input logic ovr,
                                                 input logic store);
    logic [BYTE_W-1:0] b;
    b = '0;
    b[BYTE_W-1 -: LO_W] = res[LO_W-1:0];
    b[1] = ovr;
    b[0] = store;
    return b;
  endfunction

  // a new result overruns when the old one is not fully read
  function automatic logic overrun_event(input logic seen_hi, input logic seen_lo);
    return !(seen_hi && seen_lo);
  endfunction
endpackage

// File: rtl/adc_addr_decode.sv
module adc_addr_decode #(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 8,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [NUM_CH-1:0] rd_lo_hit,
  output logic [NUM_CH-1:0] rd_hi_hit,
  output logic              sel_valid,
  output logic              sel_hi,
  output logic [CH_W-1:0]   sel_ch
);
  localparam int SPAN = 2 * NUM_CH;

  logic [ADDR_W-2:0] row;
  logic              mapped;

  assign row       = rd_addr[ADDR_W-1:1];
  assign mapped    = ({1'b0, rd_addr} < (ADDR_W+1)'(SPAN));
  assign sel_valid = rd_en && mapped;
  assign sel_hi    = rd_addr[0];
  assign sel_ch    = CH_W'(row);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_hit
    logic row_match;
    assign row_match    = sel_valid && (row == (ADDR_W-1)'(c));
    assign rd_lo_hit[c] = row_match && !rd_addr[0];
    assign rd_hi_hit[c] = row_match &&  rd_addr[0];
  end
endmodule

// File: rtl/adc_result_chan.sv
module adc_result_chan
  import adc_result_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [RES_W-1:0] wr_data,
  input  logic             rd_lo,
  input  logic             rd_hi,
  output logic [RES_W-1:0] res_q,
  output logic             store_q,
  output logic             ovr_q
);
  // tracking bits start as "read" so the first write is never an overrun
  logic seen_hi_q, seen_lo_q;
  logic ovr_hit;

  assign ovr_hit = overrun_event(seen_hi_q || rd_hi, seen_lo_q || rd_lo);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q     <= '0;
      store_q   <= 1'b0;
      ovr_q     <= 1'b0;
      seen_hi_q <= 1'b1;
      seen_lo_q <= 1'b1;
    end else if (wr) begin
      res_q     <= wr_data;
      store_q   <= 1'b1;
      ovr_q     <= ovr_hit || (ovr_q && !rd_lo);
      seen_hi_q <= 1'b0;
      seen_lo_q <= 1'b0;
    end else begin
      if (rd_lo) begin
        store_q   <= 1'b0;
        ovr_q     <= 1'b0;
        seen_lo_q <= 1'b1;
      end
      if (rd_hi) seen_hi_q <= 1'b1;
    end
  end
endmodule

// File: rtl/adc_read_mux.sv
module adc_read_mux
  import adc_result_pkg::*;
#(
  parameter int NUM_CH = 2,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0][RES_W-1:0] res,
  input  logic [NUM_CH-1:0]            store,
  input  logic [NUM_CH-1:0]            ovr,
  input  logic                         sel_valid,
  input  logic                         sel_hi,
  input  logic [CH_W-1:0]              sel_ch,
  output logic [BYTE_W-1:0]            rd_data
);
  always_comb begin
    rd_data = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (sel_valid && (sel_ch == CH_W'(c))) begin
        rd_data = sel_hi ? hi_image(res[c]) : lo_image(res[c], ovr[c], store[c]);
      end
    end
  end
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
  import adc_result_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 8,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic              cv_valid,
  input  logic [CH_W-1:0]   cv_chan,
  input  logic [9:0]        cv_data
);
  // named internal events, also watched by the checker
  logic [NUM_CH-1:0]            wr_hit;
  logic [NUM_CH-1:0]            rd_lo_hit;
  logic [NUM_CH-1:0]            rd_hi_hit;
  logic [NUM_CH-1:0][RES_W-1:0] res_q;
  logic [NUM_CH-1:0]            store_q;
  logic [NUM_CH-1:0]            ovr_q;
  logic                         sel_valid;
  logic                         sel_hi;
  logic [CH_W-1:0]              sel_ch;

  adc_addr_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .rd_lo_hit (rd_lo_hit),
    .rd_hi_hit (rd_hi_hit),
    .sel_valid (sel_valid),
    .sel_hi    (sel_hi),
    .sel_ch    (sel_ch)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign wr_hit[c] = cv_valid && (cv_chan == CH_W'(c));

    adc_result_chan u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (wr_hit[c]),
      .wr_data (cv_data),
      .rd_lo   (rd_lo_hit[c]),
      .rd_hi   (rd_hi_hit[c]),
      .res_q   (res_q[c]),
      .store_q (store_q[c]),
      .ovr_q   (ovr_q[c])
    );
  end

  adc_read_mux #(.NUM_CH(NUM_CH)) u_mux (
    .res       (res_q),
    .store     (store_q),
    .ovr       (ovr_q),
    .sel_valid (sel_valid),
    .sel_hi    (sel_hi),
    .sel_ch    (sel_ch),
    .rd_data   (rd_data)
  );
endmodule

// File: rtl/adc_result_bank_chk.sv
module adc_result_bank_chk #(
  parameter int NUM_CH = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] wr_hit,
  input logic [NUM_CH-1:0] rd_lo_hit,
  input logic [NUM_CH-1:0] rd_hi_hit,
  input logic [NUM_CH-1:0] store_q,
  input logic [NUM_CH-1:0] ovr_q
);
  AST_ONE_BYTE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_lo_hit, rd_hi_hit})); // R10

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    AST_STORE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit[c] |=> store_q[c]); // R4
    AST_LOW_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_lo_hit[c] && !wr_hit[c]) |=> (!store_q[c] && !ovr_q[c])); // R5
    AST_OVR_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_q[c]) |-> $past(wr_hit[c])); // R6
    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_hit[c] && !rd_lo_hit[c]) |=> ($stable(store_q[c]) && $stable(ovr_q[c]))); // R8
  end
endmodule

bind adc_result_bank adc_result_bank_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_hit    (wr_hit),
  .rd_lo_hit (rd_lo_hit),
  .rd_hi_hit (rd_hi_hit),
  .store_q   (store_q),
  .ovr_q     (ovr_q)
);

// File: tb/adc_result_bank_test.sv
module adc_result_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2;
  localparam int AW  = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    rd_data;
  logic          cv_valid = 1'b0;
  logic          cv_chan = 1'b0;
  logic [9:0]    cv_data = '0;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_result_bank #(.NUM_CH(NCH), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .cv_valid(cv_valid), .cv_chan(cv_chan), .cv_data(cv_data)
  );

  // vector: {op(1: read, 0: write), req[3:0], arg[5:0], data[9:0], expected[7:0]}
  // low byte = {res[1:0],4'b0,overrun,store}; high byte = res[9:2]
  localparam int NV = 21;
  localparam logic [28:0] VEC [NV] = '{
    {1'b0, 4'd4,  6'd0, 10'h2D5, 8'h00}, // R4 write ch0
    {1'b1, 4'd2,  6'd1, 10'h000, 8'hB5}, // R2 high byte
    {1'b1, 4'd4,  6'd0, 10'h000, 8'h41}, // R4 R3 store flag visible
    {1'b1, 4'd5,  6'd0, 10'h000, 8'h40}, // R5 cleared by low read
    {1'b0, 4'd6,  6'd0, 10'h3FF, 8'h00},
    {1'b0, 4'd6,  6'd0, 10'h001, 8'h00}, // R6 unread result overwritten
    {1'b1, 4'd2,  6'd1, 10'h000, 8'h00}, // R2
    {1'b1, 4'd6,  6'd0, 10'h000, 8'h43}, // R6 overrun set
    {1'b1, 4'd5,  6'd0, 10'h000, 8'h40}, // R5 both flags cleared
    {1'b0, 4'd11, 6'd1, 10'h155, 8'h00},
    {1'b1, 4'd3,  6'd2, 10'h000, 8'h41}, // R3 low read only
    {1'b0, 4'd6,  6'd1, 10'h0AA, 8'h00}, // R6 high never read
    {1'b1, 4'd8,  6'd3, 10'h000, 8'h2A}, // R8 high read keeps flags
    {1'b1, 4'd6,  6'd2, 10'h000, 8'h83}, // R6
    {1'b1, 4'd10, 6'd4, 10'h000, 8'h00}, // R10 unmapped
    {1'b1, 4'd5,  6'd2, 10'h000, 8'h80}, // R5
    {1'b0, 4'd11, 6'd0, 10'h200, 8'h00}, // R11 write other channel
    {1'b1, 4'd11, 6'd3, 10'h000, 8'h2A}, // R11
    {1'b1, 4'd11, 6'd2, 10'h000, 8'h80}, // R11
    {1'b1, 4'd2,  6'd1, 10'h000, 8'h80}, // R2
    {1'b1, 4'd7,  6'd0, 10'h000, 8'h01}  // R7 both read before: no overrun
  };

  task automatic check(input int req, input logic [7:0] exp);
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL R%0d addr=%0d actual=%02h expected=%02h", req, rd_addr, rd_data, exp);
    end
  endtask

  // one cycle: drive at negedge, sample before the rising edge
  task automatic cycle(input logic w, input logic wch, input logic [9:0] wd,
                       input logic r, input int a, input logic en,
                       input int req, input logic [7:0] exp);
    @(negedge clk);
    cv_valid = w; cv_chan = wch; cv_data = wd;
    rd_en = en; rd_addr = AW'(a);
    #1;
    if (r) check(req, exp);
    @(posedge clk);
    #1;
    cv_valid = 1'b0; rd_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 2*NCH; a++) cycle(0, 0, 0, 1, a, 1, 1, 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][28])
        cycle(0, 0, 0, 1, int'(VEC[i][23:18]), 1, int'(VEC[i][27:24]), VEC[i][7:0]);
      else
        cycle(1, VEC[i][18], VEC[i][17:8], 0, 0, 0, 0, 8'h00);
    end

    // R9 write and low read in the same cycle on ch1
    cycle(1, 1, 10'h3C0, 0, 0, 0, 0, 8'h00);
    cycle(1, 1, 10'h001, 1, 2, 1, 9, 8'h01); // old data returned
    cycle(0, 0, 0, 1, 3, 1, 9, 8'h00);       // R9 new result high byte
    cycle(0, 0, 0, 1, 2, 1, 9, 8'h43);       // R9 store and overrun set

    // R10 / R8 address without strobe
    cycle(1, 0, 10'h0C3, 0, 0, 0, 0, 8'h00);
    cycle(0, 0, 0, 1, 0, 0, 10, 8'h00);      // R10 rd_en low gives zero
    cycle(0, 0, 0, 1, 0, 1, 8, 8'hC1);       // R8 flags kept
    cycle(0, 0, 0, 1, 0, 1, 5, 8'hC0);       // R5

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule